// File: doc/BRIEF.md
# Differential Evolution Population Store and Selection Unit

This block keeps the working population of a differential-evolution optimiser together with the fitness of every individual. It also performs the greedy replacement step that closes each generation. The population is a store of NP rows by D columns of 64-bit words, and each word is one attribute of one individual. A second store holds one 64-bit fitness word per individual. A bank of D registers holds the candidate (trial) vector that the arithmetic stage produced outside this block.

The surrounding engine first fills both stores through the load port. For each candidate, it writes the D trial attributes into the register bank. It then pulses the start input together with the target row and the candidate's fitness. The block fetches the stored fitness of that row and compares the two values as unsigned 64-bit integers. This comparison is sound because both values are expected to be non-negative IEEE doubles. When the candidate wins, the block copies the whole trial vector into the row, one column per cycle, and then writes the new fitness. A single-cycle done pulse reports whether the candidate replaced the parent. The same pulse flags an error if either fitness word had its sign bit set, and in that case no replacement takes place.

Outside a selection, the engine can read any attribute of any individual, together with that individual's fitness, with a latency of one cycle.

Top module: `evo_select_core`

## Requirements
- R1: After reset, `busy`, `sel_done` and `rd_valid` are low.
- R2: While the block is idle, `ld_attr_we` writes `ld_data` to attribute (`ld_row`, `ld_col`) and `ld_fit_we` writes `ld_data` as the fitness of `ld_row`.
- R3: A read request accepted in one cycle raises `rd_valid` in the next cycle. In that cycle `rd_data` holds the requested attribute and `rd_fit` holds the fitness of the requested row.
- R4: A read request made while `busy` is high, or in the same cycle as an accepted start, is dropped, and `rd_valid` stays low in the following cycle.
- R5: The candidate replaces the parent when its fitness, taken as an unsigned 64-bit number, is less than or equal to the stored fitness. A tie therefore replaces the parent.
- R6: On replacement, all D attributes of the row become the trial register values and the row fitness becomes the candidate fitness. `sel_done` rises D+4 clock edges after the edge that samples start (counting that edge), with `sel_won` high.
- R7: When the candidate loses, the row and its fitness are unchanged. `sel_done` rises 3 edges after the start edge (counting that edge), with `sel_won` low.
- R8: If bit 63 of the candidate fitness or of the stored fitness is set, `sel_err` is high with `sel_done`, `sel_won` is low, and nothing is written. The timing is that of R7.
- R9: A start pulse while `busy` is high is ignored, and no second selection follows.
- R10: Trial register writes and load writes made while `busy` is high have no effect.
- R11: `sel_done` is a single-cycle pulse.
- R12: A replacement leaves every other row and its fitness unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_attr_we | input | 1 | Load one population attribute |
| ld_fit_we | input | 1 | Load one fitness word |
| ld_row | input | $clog2(NP) | Load row |
| ld_col | input | $clog2(D) | Load column |
| ld_data | input | 64 | Load data |
| trial_we | input | 1 | Write one trial register |
| trial_idx | input | $clog2(D) | Trial register index |
| trial_data | input | 64 | Trial attribute value |
| sel_start | input | 1 | Start a selection |
| sel_row | input | $clog2(NP) | Individual under selection |
| sel_fit | input | 64 | Candidate fitness |
| busy | output | 1 | Selection in progress |
| sel_done | output | 1 | Selection finished (one-cycle pulse) |
| sel_won | output | 1 | Candidate replaced the parent |
| sel_err | output | 1 | Negative fitness seen |
| rd_en | input | 1 | Read request |
| rd_row | input | $clog2(NP) | Read row |
| rd_col | input | $clog2(D) | Read column |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read attribute |
| rd_fit | output | 64 | Fitness of the read row |

## Verification
Two functions can meet in the same cycle. The first is a read or a start arriving at the same moment that a selection begins or is already running. The second is a trial or load write that overlaps the write-back. The bench raises a read together with a start while the block is idle. In the middle of a winning selection it also asserts a read, a second start, a trial write and a load write together. The outcome is judged afterwards at the ports: `rd_valid` must stay low, no second `sel_done` may follow, and reading the row back must return the original trial vector and fitness, not the stray data.

// File: rtl/evo_sel_pkg.sv
package evo_sel_pkg;
  localparam int WORD_W = 64;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_CMP   = 3'd2,
    ST_WB    = 3'd3,
    ST_WFIT  = 3'd4
  } sel_state_e;

  // Sign bit of an IEEE double; unsigned ordering only holds when clear
  function automatic logic fit_is_neg(word_t v);
    return v[WORD_W-1];
  endfunction

  // Non-negative doubles order like their unsigned bit patterns
  function automatic logic cand_beats(word_t cand, word_t held);
    return cand <= held;
  endfunction
endpackage

// File: rtl/pop_store.sv
module pop_store
  import evo_sel_pkg::*;
#(
  parameter int NP = 16,
  parameter int D  = 4,
  parameter int IW = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] wrow,
  input  logic [CW-1:0] wcol,
  input  word_t         wdata,
  input  logic          re,
  input  logic [IW-1:0] rrow,
  input  logic [CW-1:0] rcol,
  output word_t         rdata
);
  word_t mem [NP][D];

  always_ff @(posedge clk) begin
    if (we && (int'(wrow) < NP) && (int'(wcol) < D))
      mem[wrow][wcol] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re && (int'(rrow) < NP) && (int'(rcol) < D))
      rdata <= mem[rrow][rcol];
  end
endmodule

// File: rtl/fit_store.sv
module fit_store
  import evo_sel_pkg::*;
#(
  parameter int NP = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] wrow,
  input  word_t         wdata,
  input  logic          re,
  input  logic [IW-1:0] rrow,
  output word_t         rdata
);
  word_t mem [NP];

  always_ff @(posedge clk) begin
    if (we && (int'(wrow) < NP))
      mem[wrow] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re && (int'(rrow) < NP))
      rdata <= mem[rrow];
  end
endmodule

// File: rtl/trial_regfile.sv
module trial_regfile
  import evo_sel_pkg::*;
#(
  parameter int D  = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] widx,
  input  word_t         wdata,
  input  logic [CW-1:0] ridx,
  output word_t         rdata
);
  word_t regs [D];

  for (genvar g = 0; g < D; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && (int'(widx) == g))
        regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < D; k++)
      if (int'(ridx) == k) rdata = regs[k];
  end
endmodule

// File: rtl/sel_ctrl.sv
module sel_ctrl
  import evo_sel_pkg::*;
#(
  parameter int D  = 4,
  parameter int IW = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [IW-1:0] row,
  input  word_t         cand_fit,
  input  word_t         held_fit,
  output logic          busy,
  output logic          fetch,
  output logic [IW-1:0] row_q,
  output word_t         cand_q,
  output logic          cmp_win,
  output logic          wb_attr_we,
  output logic          wb_fit_we,
  output logic [CW-1:0] wb_col,
  output logic          done,
  output logic          won,
  output logic          err
);
  localparam logic [CW-1:0] LAST_COL = CW'(D - 1);

  sel_state_e state;
  logic       cmp_err;

  assign busy       = (state != ST_IDLE);
  assign fetch      = (state == ST_FETCH);
  assign cmp_err    = fit_is_neg(cand_q) | fit_is_neg(held_fit);
  assign cmp_win    = (state == ST_CMP) && !cmp_err && cand_beats(cand_q, held_fit);
  assign wb_attr_we = (state == ST_WB);
  assign wb_fit_we  = (state == ST_WFIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      row_q  <= '0;
      cand_q <= '0;
      wb_col <= '0;
      done   <= 1'b0;
      won    <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            row_q  <= row;
            cand_q <= cand_fit;
            state  <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_CMP;
        ST_CMP: begin
          if (cmp_win) begin
            wb_col <= '0;
            state  <= ST_WB;
          end else begin
            done  <= 1'b1;
            won   <= 1'b0;
            err   <= cmp_err;
            state <= ST_IDLE;
          end
        end
        ST_WB: begin
          wb_col <= wb_col + 1'b1;
          if (wb_col == LAST_COL) state <= ST_WFIT;
        end
        ST_WFIT: begin
          done  <= 1'b1;
          won   <= 1'b1;
          err   <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evo_select_core.sv
module evo_select_core
  import evo_sel_pkg::*;
#(
  parameter int NP = 16,
  parameter int D  = 4,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1,
  localparam int CW = (D > 1) ? $clog2(D) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_attr_we,
  input  logic          ld_fit_we,
  input  logic [IW-1:0] ld_row,
  input  logic [CW-1:0] ld_col,
  input  logic [63:0]   ld_data,
  input  logic          trial_we,
  input  logic [CW-1:0] trial_idx,
  input  logic [63:0]   trial_data,
  input  logic          sel_start,
  input  logic [IW-1:0] sel_row,
  input  logic [63:0]   sel_fit,
  output logic          busy,
  output logic          sel_done,
  output logic          sel_won,
  output logic          sel_err,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic          rd_valid,
  output logic [63:0]   rd_data,
  output logic [63:0]   rd_fit
);
  logic          fetch, cmp_win, wb_attr_we, wb_fit_we, rd_acc;
  logic [IW-1:0] row_q;
  logic [CW-1:0] wb_col;
  word_t         cand_q, held_fit, trial_word;
  logic          pop_we, fit_we;

  assign rd_acc = rd_en && !busy && !sel_start;
  assign pop_we = wb_attr_we | (ld_attr_we & !busy);
  assign fit_we = wb_fit_we  | (ld_fit_we  & !busy);

  sel_ctrl #(.D(D), .IW(IW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(sel_start), .row(sel_row),
    .cand_fit(sel_fit), .held_fit(held_fit), .busy(busy), .fetch(fetch),
    .row_q(row_q), .cand_q(cand_q), .cmp_win(cmp_win),
    .wb_attr_we(wb_attr_we), .wb_fit_we(wb_fit_we), .wb_col(wb_col),
    .done(sel_done), .won(sel_won), .err(sel_err)
  );

  trial_regfile #(.D(D), .CW(CW)) u_trial (
    .clk(clk), .rst_n(rst_n), .we(trial_we && !busy), .widx(trial_idx),
    .wdata(trial_data), .ridx(wb_col), .rdata(trial_word)
  );

  pop_store #(.NP(NP), .D(D), .IW(IW), .CW(CW)) u_pop (
    .clk(clk), .we(pop_we),
    .wrow(busy ? row_q : ld_row), .wcol(busy ? wb_col : ld_col),
    .wdata(busy ? trial_word : ld_data),
    .re(rd_acc), .rrow(rd_row), .rcol(rd_col), .rdata(rd_data)
  );

  fit_store #(.NP(NP), .IW(IW)) u_fit (
    .clk(clk), .we(fit_we), .wrow(busy ? row_q : ld_row),
    .wdata(busy ? cand_q : ld_data),
    .re(fetch | rd_acc), .rrow(busy ? row_q : rd_row), .rdata(held_fit)
  );

  assign rd_fit = held_fit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_acc;
  end
endmodule

// File: rtl/evo_select_chk.sv
module evo_select_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_start,
  input logic busy,
  input logic sel_done,
  input logic sel_won,
  input logic sel_err,
  input logic rd_en,
  input logic rd_valid,
  input logic cmp_win,
  input logic wb_attr_we,
  input logic wb_fit_we
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_done |=> !sel_done);  // R11
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy && !sel_start) |=> rd_valid);  // R3
  AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (busy || sel_start)) |=> !rd_valid);  // R4
  AST_ERR_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_done && sel_err) |-> !sel_won);  // R8
  AST_WIN_TO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_win |=> wb_attr_we);  // R6
  AST_FIT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fit_we |=> (sel_done && sel_won));  // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_start && !busy) |=> busy);  // R9
endmodule

bind evo_select_core evo_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .busy(busy),
  .sel_done(sel_done), .sel_won(sel_won), .sel_err(sel_err),
  .rd_en(rd_en), .rd_valid(rd_valid), .cmp_win(cmp_win),
  .wb_attr_we(wb_attr_we), .wb_fit_we(wb_fit_we)
);

// File: tb/evo_select_core_test.sv
module evo_select_core_test;
  localparam int NP = 16;
  localparam int D  = 4;
  localparam int IW = $clog2(NP);
  localparam int CW = $clog2(D);

  logic clk = 0, rst_n = 0;
  logic ld_attr_we = 0, ld_fit_we = 0, trial_we = 0, sel_start = 0, rd_en = 0;
  logic [IW-1:0] ld_row = 0, sel_row = 0, rd_row = 0;
  logic [CW-1:0] ld_col = 0, trial_idx = 0, rd_col = 0;
  logic [63:0] ld_data = 0, trial_data = 0, sel_fit = 0;
  logic busy, sel_done, sel_won, sel_err, rd_valid;
  logic [63:0] rd_data, rd_fit;

  int checks = 0, errors = 0, cyc = 0;
  logic [63:0] exp_pop [NP][D];
  logic [63:0] exp_fit [NP];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  evo_select_core #(.NP(NP), .D(D)) uut (.*);

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(int r, int c);
    return {16'h3FF0, 16'(r), 16'(c), 16'hA5A5};
  endfunction

  task automatic rd(input int r, input int c, output logic v, output logic [63:0] a, output logic [63:0] f);
    @(negedge clk); rd_en = 1; rd_row = IW'(r); rd_col = CW'(c);
    @(posedge clk); @(negedge clk); rd_en = 0;
    v = rd_valid; a = rd_data; f = rd_fit;
  endtask

  task automatic verify_row(input int r, input string tag);
    logic v; logic [63:0] a, f;
    for (int c = 0; c < D; c++) begin
      rd(r, c, v, a, f);
      chk(v && a == exp_pop[r][c] && f == exp_fit[r], tag, a, exp_pop[r][c]);
    end
  endtask

  task automatic load_trial(input logic [63:0] base);
    for (int c = 0; c < D; c++) begin
      @(negedge clk); trial_we = 1; trial_idx = CW'(c); trial_data = base + 64'(c);
    end
    @(negedge clk); trial_we = 0;
  endtask

  task automatic run_sel(input int r, input logic [63:0] f, output int n, output logic w, output logic e);
    @(negedge clk); sel_start = 1; sel_row = IW'(r); sel_fit = f;
    @(posedge clk); n = 1; @(negedge clk); sel_start = 0;
    while (!sel_done && n < 100) begin @(posedge clk); n++; @(negedge clk); end
    w = sel_won; e = sel_err;
    @(posedge clk); @(negedge clk);
    chk(!sel_done, "R11 done pulse width", 64'(sel_done), 0);
  endtask

  task automatic t_reset;
    chk(!busy && !sel_done && !rd_valid, "R1 reset outputs", {61'd0, busy, sel_done, rd_valid}, 0);
  endtask

  task automatic t_load;
    for (int r = 0; r < NP; r++) begin
      for (int c = 0; c < D; c++) begin
        @(negedge clk); ld_attr_we = 1; ld_row = IW'(r); ld_col = CW'(c); ld_data = pat(r, c);
        exp_pop[r][c] = pat(r, c);
      end
      @(negedge clk); ld_attr_we = 0; ld_fit_we = 1; ld_row = IW'(r);
      ld_data = 64'h4000_0000_0000_0000 + 64'(r * 16); exp_fit[r] = ld_data;
      @(negedge clk); ld_fit_we = 0;
    end
    verify_row(3, "R2 load and R3 read row 3");
    verify_row(NP - 1, "R2 load last row");
  endtask

  task automatic t_win;
    int n; logic w, e; logic [63:0] tf;
    load_trial(64'h3FE0_0000_0000_1000);
    tf = exp_fit[5] - 64'd1;
    run_sel(5, tf, n, w, e);
    chk(n == D + 4, "R6 win latency", 64'(n), 64'(D + 4));
    chk(w && !e, "R5 smaller fitness wins", {62'd0, w, e}, 64'd2);
    for (int c = 0; c < D; c++) exp_pop[5][c] = 64'h3FE0_0000_0000_1000 + 64'(c);
    exp_fit[5] = tf;
    verify_row(5, "R6 row replaced");
    verify_row(4, "R12 neighbour row 4 intact");
    verify_row(6, "R12 neighbour row 6 intact");
  endtask

  task automatic t_tie;
    int n; logic w, e;
    load_trial(64'h3FD0_0000_0000_2000);
    run_sel(7, exp_fit[7], n, w, e);
    chk(w, "R5 tie replaces", 64'(w), 1);
    for (int c = 0; c < D; c++) exp_pop[7][c] = 64'h3FD0_0000_0000_2000 + 64'(c);
    verify_row(7, "R5 tie row replaced");
  endtask

  task automatic t_lose;
    int n; logic w, e;
    load_trial(64'h1111_0000_0000_0000);
    run_sel(8, exp_fit[8] + 64'd1, n, w, e);
    chk(n == 3, "R7 lose latency", 64'(n), 3);
    chk(!w && !e, "R7 larger fitness loses", {62'd0, w, e}, 0);
    verify_row(8, "R7 row unchanged");
  endtask

  task automatic t_err;
    int n; logic w, e;
    load_trial(64'h2222_0000_0000_0000);
    run_sel(9, 64'h8000_0000_0000_0000, n, w, e);
    chk(e && !w && n == 3, "R8 negative candidate", {62'd0, w, e}, 1);
    verify_row(9, "R8 row untouched after negative candidate");
    @(negedge clk); ld_fit_we = 1; ld_row = IW'(10); ld_data = 64'hC000_0000_0000_0000;
    exp_fit[10] = ld_data;
    @(negedge clk); ld_fit_we = 0;
    run_sel(10, 64'h0000_0000_0000_0001, n, w, e);
    chk(e && !w, "R8 negative stored fitness", {62'd0, w, e}, 1);
    verify_row(10, "R8 row untouched after negative stored");
  endtask

  task automatic t_collide;
    int n; logic [63:0] tf;
    // read together with accepted start
    load_trial(64'h3333_0000_0000_0000);
    tf = exp_fit[11] - 64'd5;
    @(negedge clk); sel_start = 1; sel_row = IW'(11); sel_fit = tf; rd_en = 1; rd_row = 0; rd_col = 0;
    @(posedge clk); @(negedge clk); sel_start = 0; rd_en = 0;
    chk(!rd_valid, "R4 read with start dropped", 64'(rd_valid), 0);
    // everything at once while busy
    rd_en = 1; sel_start = 1; sel_row = IW'(12); sel_fit = 64'd0;
    trial_we = 1; trial_idx = 0; trial_data = 64'hDEAD;
    ld_attr_we = 1; ld_fit_we = 1; ld_row = IW'(13); ld_col = 0; ld_data = 64'hBEEF;
    @(posedge clk); @(negedge clk);
    rd_en = 0; sel_start = 0; trial_we = 0; ld_attr_we = 0; ld_fit_we = 0;
    chk(!rd_valid, "R4 read while busy dropped", 64'(rd_valid), 0);
    n = 0;
    while (!sel_done && n < 100) begin @(posedge clk); n++; @(negedge clk); end
    chk(sel_won, "R6 collided selection wins", 64'(sel_won), 1);
    n = 0;
    for (int k = 0; k < 8; k++) begin @(posedge clk); @(negedge clk); if (sel_done || busy) n++; end
    chk(n == 0, "R9 second start ignored", 64'(n), 0);
    for (int c = 0; c < D; c++) exp_pop[11][c] = 64'h3333_0000_0000_0000 + 64'(c);
    exp_fit[11] = tf;
    verify_row(11, "R10 trial write while busy ignored");
    verify_row(12, "R9 row 12 untouched");
    verify_row(13, "R10 load while busy ignored");
  endtask

  initial begin
    wait (cyc == 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_load();
    t_win();
    t_tie();
    t_lose();
    t_err();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule